// File: doc/BRIEF.md
# DRAM Row-Buffer Stall Tracker

This block sits on the write path that carries update records toward their bins in DRAM. It models the DRAM row buffer as a single open-row register per bank. Each incoming write address is split into column, bank and row fields. The block then classifies the write as one of three cases:

- a row hit;
- a row miss in the bank that served the previous write;
- a row miss that moves to another bank.

On a miss it holds back the upstream producer for a fixed penalty before passing the address on. A hit passes in the same cycle.

The address path is combinational. The output address is the input address, and the handshake follows valid/ready on both sides. Six counters sum up the traffic seen since reset:

- hits;
- misses of each kind;
- row activations;
- activations that were not the first touch of a bank;
- cycles of imposed stall.

The block is used to measure how much a write ordering costs. An ordering sorted by destination keeps consecutive writes in one row and so cuts the activations. A scattered ordering pays the penalty on nearly every write.

Top module: `dram_row_stall_tracker`

## Requirements
- R1: An address is split with the column in bits [COL_W-1:0], the bank in the next BANK_W bits, and the row in the top ROW_W bits.
- R2: A write whose bank has an open row equal to its row field is a hit. It is forwarded in the cycle it is presented, with out_valid equal to in_valid and in_ready equal to out_ready, and it adds no stall.
- R3: A miss whose bank equals the bank of the last forwarded write keeps in_ready low for exactly SAME_STALL cycles (default 9), counted from the first cycle it is presented. It is then forwarded.
- R4: Any other miss keeps in_ready low for exactly CROSS_STALL cycles (default 5). This covers a different bank, and also the case where no write has been forwarded since reset. The write is then forwarded.
- R5: out_addr always equals in_addr. An accepted write is always forwarded in the same cycle (out_valid is high). in_ready is never high while out_ready is low.
- R6: On each forwarded write, the open row of its bank becomes its row field, and the other banks keep their open rows. A miss to a bank that was already open counts as a non-compulsory activation. A miss to a bank with no open row counts only as a compulsory one.
- R7: Each forwarded write adds one to exactly one of cnt_hit, cnt_miss_same or cnt_miss_cross. Every miss adds one to cnt_act.
- R8: cnt_stall counts only the cycles of imposed penalty. Cycles spent waiting on a low out_ready are not counted, whether before or after the penalty.
- R9: Reset closes every bank, forgets the last bank, clears all six counters, and leaves out_valid low while in_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Upstream write address valid |
| in_ready | output | 1 | Upstream may hand over the address |
| in_addr | input | ADDR_W | Write address (row, bank, column) |
| out_valid | output | 1 | Forwarded address valid |
| out_ready | input | 1 | Downstream accepts the address |
| out_addr | output | ADDR_W | Forwarded write address |
| cnt_hit | output | CNT_W | Row hits forwarded |
| cnt_miss_same | output | CNT_W | Same-bank misses forwarded |
| cnt_miss_cross | output | CNT_W | Cross-bank misses forwarded |
| cnt_act | output | CNT_W | Row activations |
| cnt_act_nc | output | CNT_W | Non-compulsory row activations |
| cnt_stall | output | CNT_W | Cycles of imposed stall |

## Verification
The bench builds the block with four banks, only eight rows and a 4-bit column, and keeps the default penalties of 9 and 5 cycles. The small row space makes hits common under random traffic, next to same-bank and cross-bank misses. The four banks let every bank be opened early and then reopened, so non-compulsory activations appear often. The 16-bit counters still leave room for the whole run without wrapping.

// File: rtl/rowstall_pkg.sv
`timescale 1ns/1ps
package rowstall_pkg;

    typedef enum logic [1:0] {
        ACC_HIT        = 2'd0,
        ACC_MISS_SAME  = 2'd1,
        ACC_MISS_CROSS = 2'd2
    } acc_kind_e;

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_HOLD  = 2'd1,
        SEQ_GRANT = 2'd2
    } seq_state_e;

    typedef struct packed {
        acc_kind_e kind;
        logic      fresh_bank;
    } acc_class_t;

    localparam int EV_HIT   = 0;
    localparam int EV_SAME  = 1;
    localparam int EV_CROSS = 2;
    localparam int EV_ACT   = 3;
    localparam int EV_NC    = 4;
    localparam int EV_STALL = 5;
    localparam int EV_NUM   = 6;

    function automatic int unsigned stall_cycles(acc_kind_e k,
                                                 int unsigned same_n,
                                                 int unsigned cross_n);
        case (k)
            ACC_MISS_SAME:  return same_n;
            ACC_MISS_CROSS: return cross_n;
            default:        return 0;
        endcase
    endfunction

    function automatic int unsigned max_u(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/open_row_table.sv
`timescale 1ns/1ps
module open_row_table #(
    parameter  int BANK_W = 2,
    parameter  int ROW_W  = 12,
    localparam int NBANK  = 1 << BANK_W
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         wr_en,
    input  logic [BANK_W-1:0]            wr_bank,
    input  logic [ROW_W-1:0]             wr_row,
    output logic [NBANK-1:0][ROW_W-1:0]  open_row,
    output logic [NBANK-1:0]             open_vld,
    output logic                         last_vld,
    output logic [BANK_W-1:0]            last_bank
);

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        logic [ROW_W-1:0] row_q;
        logic             vld_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                row_q <= '0;
                vld_q <= 1'b0;
            end else if (wr_en && (wr_bank == BANK_W'(b))) begin
                row_q <= wr_row;
                vld_q <= 1'b1;
            end
        end

        assign open_row[b] = row_q;
        assign open_vld[b] = vld_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            last_vld  <= 1'b0;
            last_bank <= '0;
        end else if (wr_en) begin
            last_vld  <= 1'b1;
            last_bank <= wr_bank;
        end
    end

endmodule

// File: rtl/access_classifier.sv
`timescale 1ns/1ps
module access_classifier
    import rowstall_pkg::*;
#(
    parameter  int BANK_W = 2,
    parameter  int ROW_W  = 12,
    localparam int NBANK  = 1 << BANK_W
) (
    input  logic [BANK_W-1:0]            bank,
    input  logic [ROW_W-1:0]             row,
    input  logic [NBANK-1:0][ROW_W-1:0]  open_row,
    input  logic [NBANK-1:0]             open_vld,
    input  logic                         last_vld,
    input  logic [BANK_W-1:0]            last_bank,
    output acc_class_t                   cls
);

    logic bank_open;
    logic row_match;
    logic same_bank;

    always_comb begin
        bank_open = open_vld[bank];
        row_match = (open_row[bank] == row);
        same_bank = last_vld && (last_bank == bank);

        cls.fresh_bank = !bank_open;
        if (bank_open && row_match) begin
            cls.kind = ACC_HIT;
        end else if (same_bank) begin
            cls.kind = ACC_MISS_SAME;
        end else begin
            cls.kind = ACC_MISS_CROSS;
        end
    end

endmodule

// File: rtl/stall_sequencer.sv
`timescale 1ns/1ps
module stall_sequencer
    import rowstall_pkg::*;
#(
    parameter  int unsigned SAME_STALL  = 9,
    parameter  int unsigned CROSS_STALL = 5,
    localparam int unsigned MAX_STALL   = max_u(SAME_STALL, CROSS_STALL),
    localparam int          LEN_W       = $clog2(MAX_STALL + 1)
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       in_valid,
    input  logic       out_ready,
    input  acc_class_t cls,
    output logic       in_ready,
    output logic       out_valid,
    output logic       stall_active,
    output acc_class_t fire_cls
);

    seq_state_e       st_q, st_d;
    logic [LEN_W-1:0] cnt_q, cnt_d;
    acc_class_t       held_q, held_d;
    logic [LEN_W-1:0] len;

    always_comb begin
        len = LEN_W'(stall_cycles(cls.kind, SAME_STALL, CROSS_STALL));
    end

    always_comb begin
        st_d         = st_q;
        cnt_d        = cnt_q;
        held_d       = held_q;
        in_ready     = 1'b0;
        out_valid    = 1'b0;
        stall_active = 1'b0;
        fire_cls     = cls;
        unique case (st_q)
            SEQ_IDLE: begin
                if (in_valid) begin
                    if (cls.kind == ACC_HIT) begin
                        out_valid = 1'b1;
                        in_ready  = out_ready;
                    end else begin
                        stall_active = 1'b1;
                        held_d       = cls;
                        if (len <= LEN_W'(1)) begin
                            st_d = SEQ_GRANT;
                        end else begin
                            cnt_d = len - LEN_W'(1);
                            st_d  = SEQ_HOLD;
                        end
                    end
                end
            end
            SEQ_HOLD: begin
                stall_active = 1'b1;
                if (cnt_q <= LEN_W'(1)) begin
                    st_d = SEQ_GRANT;
                end else begin
                    cnt_d = cnt_q - LEN_W'(1);
                end
            end
            SEQ_GRANT: begin
                fire_cls  = held_q;
                out_valid = in_valid;
                in_ready  = out_ready;
                if (in_valid && out_ready) begin
                    st_d = SEQ_IDLE;
                end
            end
            default: begin
                st_d = SEQ_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= SEQ_IDLE;
            cnt_q  <= '0;
            held_q <= '{kind: ACC_HIT, fresh_bank: 1'b0};
        end else begin
            st_q   <= st_d;
            cnt_q  <= cnt_d;
            held_q <= held_d;
        end
    end

endmodule

// File: rtl/event_counters.sv
`timescale 1ns/1ps
module event_counters #(
    parameter int NEV   = 6,
    parameter int CNT_W = 32
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [NEV-1:0]              evt,
    output logic [NEV-1:0][CNT_W-1:0]   cnt
);

    for (genvar e = 0; e < NEV; e++) begin : g_cnt
        logic [CNT_W-1:0] val_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                val_q <= '0;
            end else if (evt[e]) begin
                val_q <= val_q + CNT_W'(1);
            end
        end

        assign cnt[e] = val_q;
    end

endmodule

// File: rtl/dram_row_stall_tracker.sv
`timescale 1ns/1ps
module dram_row_stall_tracker
    import rowstall_pkg::*;
#(
    parameter  int          COL_W       = 6,
    parameter  int          BANK_W      = 2,
    parameter  int          ROW_W       = 12,
    parameter  int unsigned SAME_STALL  = 9,
    parameter  int unsigned CROSS_STALL = 5,
    parameter  int          CNT_W       = 32,
    localparam int          ADDR_W      = COL_W + BANK_W + ROW_W,
    localparam int          NBANK       = 1 << BANK_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [ADDR_W-1:0] in_addr,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [ADDR_W-1:0] out_addr,
    output logic [CNT_W-1:0]  cnt_hit,
    output logic [CNT_W-1:0]  cnt_miss_same,
    output logic [CNT_W-1:0]  cnt_miss_cross,
    output logic [CNT_W-1:0]  cnt_act,
    output logic [CNT_W-1:0]  cnt_act_nc,
    output logic [CNT_W-1:0]  cnt_stall
);

    logic [BANK_W-1:0]              acc_bank;
    logic [ROW_W-1:0]               acc_row;
    logic [NBANK-1:0][ROW_W-1:0]    open_row;
    logic [NBANK-1:0]               open_vld;
    logic                           last_vld;
    logic [BANK_W-1:0]              last_bank;
    acc_class_t                     cls;
    acc_class_t                     fire_cls;
    acc_kind_e                      fire_kind;
    logic                           stall_active;
    logic                           fire;
    logic [EV_NUM-1:0]              evt;
    logic [EV_NUM-1:0][CNT_W-1:0]   cnt_all;

    // Field split: column low, bank next, row on top (R1)
    assign acc_bank = in_addr[COL_W +: BANK_W];
    assign acc_row  = in_addr[COL_W + BANK_W +: ROW_W];
    assign out_addr = in_addr;

    assign fire      = in_valid && in_ready;
    assign fire_kind = fire_cls.kind;

    open_row_table #(
        .BANK_W (BANK_W),
        .ROW_W  (ROW_W)
    ) u_table (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (fire),
        .wr_bank   (acc_bank),
        .wr_row    (acc_row),
        .open_row  (open_row),
        .open_vld  (open_vld),
        .last_vld  (last_vld),
        .last_bank (last_bank)
    );

    access_classifier #(
        .BANK_W (BANK_W),
        .ROW_W  (ROW_W)
    ) u_class (
        .bank      (acc_bank),
        .row       (acc_row),
        .open_row  (open_row),
        .open_vld  (open_vld),
        .last_vld  (last_vld),
        .last_bank (last_bank),
        .cls       (cls)
    );

    stall_sequencer #(
        .SAME_STALL  (SAME_STALL),
        .CROSS_STALL (CROSS_STALL)
    ) u_seq (
        .clk          (clk),
        .rst          (rst),
        .in_valid     (in_valid),
        .out_ready    (out_ready),
        .cls          (cls),
        .in_ready     (in_ready),
        .out_valid    (out_valid),
        .stall_active (stall_active),
        .fire_cls     (fire_cls)
    );

    always_comb begin
        evt           = '0;
        evt[EV_HIT]   = fire && (fire_cls.kind == ACC_HIT);
        evt[EV_SAME]  = fire && (fire_cls.kind == ACC_MISS_SAME);
        evt[EV_CROSS] = fire && (fire_cls.kind == ACC_MISS_CROSS);
        evt[EV_ACT]   = fire && (fire_cls.kind != ACC_HIT);
        evt[EV_NC]    = fire && (fire_cls.kind != ACC_HIT) && !fire_cls.fresh_bank;
        evt[EV_STALL] = stall_active;
    end

    event_counters #(
        .NEV   (EV_NUM),
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk (clk),
        .rst (rst),
        .evt (evt),
        .cnt (cnt_all)
    );

    assign cnt_hit        = cnt_all[EV_HIT];
    assign cnt_miss_same  = cnt_all[EV_SAME];
    assign cnt_miss_cross = cnt_all[EV_CROSS];
    assign cnt_act        = cnt_all[EV_ACT];
    assign cnt_act_nc     = cnt_all[EV_NC];
    assign cnt_stall      = cnt_all[EV_STALL];

endmodule

// File: rtl/rowstall_checker.sv
`timescale 1ns/1ps
module rowstall_checker
    import rowstall_pkg::*;
#(
    parameter int unsigned SAME_STALL  = 9,
    parameter int unsigned CROSS_STALL = 5,
    parameter int          CNT_W       = 32,
    parameter int          ADDR_W      = 20
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic              in_ready,
    input logic [ADDR_W-1:0] in_addr,
    input logic              out_valid,
    input logic              out_ready,
    input logic [ADDR_W-1:0] out_addr,
    input logic [CNT_W-1:0]  cnt_hit,
    input logic [CNT_W-1:0]  cnt_miss_same,
    input logic [CNT_W-1:0]  cnt_miss_cross,
    input logic [CNT_W-1:0]  cnt_act,
    input logic [CNT_W-1:0]  cnt_act_nc,
    input logic [CNT_W-1:0]  cnt_stall,
    input logic              stall_active,
    input acc_kind_e         fire_kind
);

    logic        rst_d;
    logic [15:0] win;
    logic        fire;

    assign fire = in_valid && in_ready;

    always_ff @(posedge clk) begin
        rst_d <= rst;
        if (rst) begin
            win <= '0;
        end else if (fire) begin
            win <= '0;
        end else if (stall_active) begin
            win <= win + 16'd1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst && rst_d) begin
            AST_COUNT_RESET: assert ((cnt_hit == '0) && (cnt_miss_same == '0) &&
                                     (cnt_miss_cross == '0) && (cnt_act == '0) &&
                                     (cnt_act_nc == '0) && (cnt_stall == '0)); // R9
        end
    end

    AST_ACCEPT_FORWARDS: assert property (@(posedge clk) disable iff (rst)
        fire |-> (out_valid && (out_addr == in_addr))); // R5

    AST_READY_NEEDS_OUT: assert property (@(posedge clk) disable iff (rst)
        in_ready |-> out_ready); // R5

    AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        stall_active |-> !in_ready); // R8

    AST_HIT_FREE: assert property (@(posedge clk) disable iff (rst)
        (fire && (fire_kind == ACC_HIT)) |-> (win == 16'd0)); // R2

    AST_SAME_WINDOW: assert property (@(posedge clk) disable iff (rst)
        (fire && (fire_kind == ACC_MISS_SAME)) |-> (win == 16'(SAME_STALL))); // R3

    AST_CROSS_WINDOW: assert property (@(posedge clk) disable iff (rst)
        (fire && (fire_kind == ACC_MISS_CROSS)) |-> (win == 16'(CROSS_STALL))); // R4

    AST_ONE_CLASS: assert property (@(posedge clk) disable iff (rst)
        fire |=> ($countones({cnt_hit != $past(cnt_hit),
                              cnt_miss_same != $past(cnt_miss_same),
                              cnt_miss_cross != $past(cnt_miss_cross)}) == 1)); // R7

    AST_ACT_SUM: assert property (@(posedge clk) disable iff (rst)
        cnt_act == CNT_W'(cnt_miss_same + cnt_miss_cross)); // R7

    AST_NC_BOUND: assert property (@(posedge clk) disable iff (rst)
        cnt_act_nc <= cnt_act); // R6

endmodule

bind dram_row_stall_tracker rowstall_checker #(
    .SAME_STALL  (SAME_STALL),
    .CROSS_STALL (CROSS_STALL),
    .CNT_W       (CNT_W),
    .ADDR_W      (ADDR_W)
) u_chk (
    .clk            (clk),
    .rst            (rst),
    .in_valid       (in_valid),
    .in_ready       (in_ready),
    .in_addr        (in_addr),
    .out_valid      (out_valid),
    .out_ready      (out_ready),
    .out_addr       (out_addr),
    .cnt_hit        (cnt_hit),
    .cnt_miss_same  (cnt_miss_same),
    .cnt_miss_cross (cnt_miss_cross),
    .cnt_act        (cnt_act),
    .cnt_act_nc     (cnt_act_nc),
    .cnt_stall      (cnt_stall),
    .stall_active   (stall_active),
    .fire_kind      (fire_kind)
);

// File: tb/tb_dram_row_stall_tracker.sv
`timescale 1ns/1ps
module tb_dram_row_stall_tracker;

    localparam int COL_W   = 4;
    localparam int BANK_W  = 2;
    localparam int ROW_W   = 3;
    localparam int SAME_N  = 9;
    localparam int CROSS_N = 5;
    localparam int CNT_W   = 16;
    localparam int ADDR_W  = COL_W + BANK_W + ROW_W;
    localparam int NBANK   = 1 << BANK_W;
    localparam int WDOG    = 150000;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              in_valid = 1'b0;
    logic              in_ready;
    logic [ADDR_W-1:0] in_addr = '0;
    logic              out_valid;
    logic              out_ready = 1'b1;
    logic [ADDR_W-1:0] out_addr;
    logic [CNT_W-1:0]  cnt_hit, cnt_miss_same, cnt_miss_cross;
    logic [CNT_W-1:0]  cnt_act, cnt_act_nc, cnt_stall;

    always #2 clk = ~clk;

    dram_row_stall_tracker #(
        .COL_W       (COL_W),
        .BANK_W      (BANK_W),
        .ROW_W       (ROW_W),
        .SAME_STALL  (SAME_N),
        .CROSS_STALL (CROSS_N),
        .CNT_W       (CNT_W)
    ) dut (
        .clk            (clk),
        .rst            (rst),
        .in_valid       (in_valid),
        .in_ready       (in_ready),
        .in_addr        (in_addr),
        .out_valid      (out_valid),
        .out_ready      (out_ready),
        .out_addr       (out_addr),
        .cnt_hit        (cnt_hit),
        .cnt_miss_same  (cnt_miss_same),
        .cnt_miss_cross (cnt_miss_cross),
        .cnt_act        (cnt_act),
        .cnt_act_nc     (cnt_act_nc),
        .cnt_stall      (cnt_stall)
    );

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // bench model of the row buffer
    int  m_row [NBANK];
    bit  m_vld [NBANK];
    bit  m_last_vld;
    int  m_last_bank;
    int  e_hit, e_same, e_cross, e_act, e_nc, e_stall;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic logic [ADDR_W-1:0] mk_addr(int row, int bank, int col);
        // R1: row on top, bank in the middle, column low
        return {ROW_W'(row), BANK_W'(bank), COL_W'(col)};
    endfunction

    // 0 hit, 1 same-bank miss, 2 cross-bank miss
    function automatic int exp_kind(int row, int bank);
        if (m_vld[bank] && m_row[bank] == row) return 0;
        if (m_last_vld && m_last_bank == bank) return 1;
        return 2;
    endfunction

    task automatic send(input int row, input int bank, input int col, input int bp,
                        input string req);
        int kind, stall, waits;
        logic [ADDR_W-1:0] a;
        kind  = exp_kind(row, bank);
        stall = (kind == 1) ? SAME_N : (kind == 2) ? CROSS_N : 0;
        a     = mk_addr(row, bank, col);
        waits = 0;
        @(negedge clk);
        in_valid  = 1'b1;
        in_addr   = a;
        out_ready = (bp == 0);
        #1;
        if (kind == 0 && bp > 0)
            chk(out_valid && !in_ready, "R5", "hit under backpressure valid/ready",
                {out_valid, in_ready}, 2'b10);
        while (!in_ready) begin
            @(negedge clk);
            waits++;
            if (waits >= stall + bp) out_ready = 1'b1;
            #1;
            if (waits > 60) break;
        end
        chk(waits == stall + bp, req, "cycles with in_ready low", waits, stall + bp);
        chk(out_valid && out_addr == a, "R5", "forwarded address", out_addr, a);
        @(posedge clk);
        // model update (R6/R7/R8)
        if (kind == 0) e_hit++;
        else begin
            e_act++;
            if (m_vld[bank]) e_nc++;
            if (kind == 1) e_same++; else e_cross++;
        end
        e_stall += stall;
        m_row[bank] = row;
        m_vld[bank] = 1'b1;
        m_last_vld  = 1'b1;
        m_last_bank = bank;
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        in_valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic check_counters(input string phase);
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        chk(cnt_hit == CNT_W'(e_hit), "R7", {phase, " cnt_hit"}, cnt_hit, e_hit);
        chk(cnt_miss_same == CNT_W'(e_same), "R7", {phase, " cnt_miss_same"}, cnt_miss_same, e_same);
        chk(cnt_miss_cross == CNT_W'(e_cross), "R7", {phase, " cnt_miss_cross"}, cnt_miss_cross, e_cross);
        chk(cnt_act == CNT_W'(e_act), "R7", {phase, " cnt_act"}, cnt_act, e_act);
        chk(cnt_act_nc == CNT_W'(e_nc), "R6", {phase, " cnt_act_nc"}, cnt_act_nc, e_nc);
        chk(cnt_stall == CNT_W'(e_stall), "R8", {phase, " cnt_stall"}, cnt_stall, e_stall);
    endtask

    initial begin
        for (int b = 0; b < NBANK; b++) begin
            m_row[b] = 0;
            m_vld[b] = 1'b0;
        end
        m_last_vld = 1'b0;
        m_last_bank = 0;
        e_hit = 0; e_same = 0; e_cross = 0; e_act = 0; e_nc = 0; e_stall = 0;
        void'($urandom(32'h0BAD_5EED));

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R9 reset state
        chk(out_valid == 1'b0, "R9", "out_valid after reset", out_valid, 0);
        chk(cnt_act == '0 && cnt_stall == '0, "R9", "counters after reset",
            cnt_act + cnt_stall, 0);
        chk(cnt_hit == '0 && cnt_miss_same == '0 && cnt_miss_cross == '0 && cnt_act_nc == '0,
            "R9", "class counters after reset",
            cnt_hit + cnt_miss_same + cnt_miss_cross + cnt_act_nc, 0);

        // directed corner cases
        send(1, 0, 0, 0, "R4");   // first ever write: cross, compulsory
        send(1, 0, 5, 0, "R2");   // same row: hit
        send(2, 0, 0, 0, "R3");   // same bank, new row
        send(3, 1, 0, 0, "R4");   // other bank, first touch
        send(2, 0, 7, 0, "R6");   // bank0 kept its row: hit
        send(3, 0, 0, 0, "R3");   // last bank was 0
        send(3, 1, 2, 0, "R6");   // bank1 row still open: hit
        send(4, 0, 0, 0, "R4");   // last bank 1, bank0 reopened
        send(4, 0, 1, 3, "R2");   // hit held by backpressure only
        send(5, 0, 0, 4, "R8");   // same-bank miss plus backpressure
        for (int c = 0; c < 8; c++) send(5, 0, c, 0, "R2"); // sorted run
        idle(2);
        send(6, 2, 3, 0, "R4");
        send(6, 3, 3, 0, "R4");
        send(7, 3, 3, 0, "R3");
        check_counters("directed");
        chk(cnt_act_nc < cnt_act, "R6", "compulsory activations excluded",
            cnt_act_nc, e_nc);

        // constrained random traffic
        begin
            int pr, pb;
            pr = 0; pb = 0;
            for (int i = 0; i < 400; i++) begin
                int r, b, c, bp;
                if ($urandom_range(0, 99) < 35) begin
                    r = pr; b = pb;
                end else begin
                    r = $urandom_range(0, (1 << ROW_W) - 1);
                    b = $urandom_range(0, NBANK - 1);
                end
                c  = $urandom_range(0, (1 << COL_W) - 1);
                bp = ($urandom_range(0, 9) == 0) ? $urandom_range(1, 3) : 0;
                send(r, b, c, bp, "R3/R4 random");
                if ($urandom_range(0, 4) == 0) idle($urandom_range(0, 2));
                pr = r; pb = b;
            end
        end
        check_counters("random");

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(WDOG * 4);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog R3 run did not complete actual=%0d expected=%0d", 0, 1);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule